// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 64K words by 4 bits. The RAM has separate data-in and data-out pins. The host offers one word at a time: a request with a write flag, a 16-bit word address and 4 bits of write data. The controller turns each request into a strobe sequence on the memory pins, with every strobe registered. The sequence lengths are set by three parameters, each a whole number of clock periods: write-enable pulse width `T_WP`, write cycle length `T_WC` and read access time `T_AA`.

Chip select and write enable are both active low. A write drops both strobes together. Write enable rises after `T_WP` cycles and ends the write. Address and write data stay unchanged through that rising edge and for the rest of the access. A read keeps write enable high and holds the address. The data pins are registered exactly `T_AA` cycles after the address reaches the memory, and a one-cycle valid pulse marks the capture. Between accesses chip select is high, so the RAM stays in its power-down state. The host may present a request only while `ready` is high, and `ready` stays low for the whole access.

Top module: `sram_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `memCeN` and `memWeN` to 1, `ready` to 1, `rdValid` to 0 and `rdData` to 0.
- R2: While `ready` is 1 (no access in progress), `memCeN` is 1.
- R3: A request is accepted on a rising edge where `reqValid` and `ready` are both 1. For a write (`reqWrite`=1), `memCeN` and `memWeN` are both 0 from the next cycle, and `memWeN` stays 0 for exactly `T_WP` cycles.
- R4: From the cycle after acceptance until `ready` returns to 1, `memAddr` and `memDin` equal the accepted address and data and do not change. This covers the edge on which `memWeN` rises.
- R5: `memWeN` is never 0 while `memCeN` is 1, so every write ends on the rising edge of write enable.
- R6: For a read (`reqWrite`=0), `memWeN` stays 1 and `memCeN` is 0 for `T_AA` cycles. On the edge `T_AA` cycles after the address is driven, `memDout` is registered into `rdData`, and `rdValid` is 1 for exactly that one following cycle.
- R7: `ready` goes to 0 in the cycle after acceptance and returns to 1 after `T_WC` cycles for a write or `T_AA` cycles for a read. `memCeN` returns to 1 at the same time.
- R8: A request presented while `ready` is 0 is ignored. It changes neither the memory pins nor the stored contents, and it starts no access afterwards.
- R9: A write never asserts `rdValid`. `rdData` keeps the last read word until the next read completes.
- R10: Reset asserted in the middle of an access ends it on the next edge. Both strobes return to 1 and `ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Host word address |
| reqWdata | input | 4 | Host write data |
| ready | output | 1 | Controller can take a request |
| rdValid | output | 1 | One-cycle pulse: `rdData` holds new read data |
| rdData | output | 4 | Last word read |
| memAddr | output | 16 | Address to the RAM |
| memCeN | output | 1 | RAM chip select, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memDin | output | 4 | Data to the RAM input pins |
| memDout | input | 4 | Data from the RAM output pins |

## Verification
An off-by-one in the cycle counter shows up in the access it affects. Either the write-enable pulse is one cycle too long or too short, or `ready` and `rdValid` arrive a cycle early or late. The bench counts each of these per cycle against `T_WP`, `T_WC` and `T_AA`. A stale or wrongly loaded address or data register shows at `memAddr` in the first cycle after acceptance, or later as a wrong word on read-back. A control state that fails to leave an access, or that accepts a request while busy, shows within one access length as `ready` stuck at 0 or as strobes with no accepted request.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic latchReq;   // load host address and data
    logic ceOn;       // chip select asserted
    logic weOn;       // write enable asserted
    logic captureRd;  // sample memory output this edge
  } strobeT;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } stateT;

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int T_WP = 1,
  parameter int T_WC = 2,
  parameter int T_AA = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   ready,
  output strobeT strb
);

  localparam int MAX_T = (T_WC > T_AA) ? T_WC : T_AA;
  localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(T_WP - 1);
  localparam logic [CNT_W-1:0] WC_LAST = CNT_W'(T_WC - 1);
  localparam logic [CNT_W-1:0] AA_LAST = CNT_W'(T_AA - 1);

  if (T_WP < 1 || T_AA < 1 || T_WC < T_WP) begin : g_badParams
    $error("sram_ctrl_fsm: need T_WP>=1, T_AA>=1, T_WC>=T_WP");
  end

  stateT           state;
  logic [CNT_W-1:0] cnt;
  logic            isWrite;
  logic            weOn;
  logic            accept;
  logic            lastCycle;

  assign ready     = (state == ST_IDLE);
  assign accept    = ready && reqValid;
  assign lastCycle = isWrite ? (cnt == WC_LAST) : (cnt == AA_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      weOn    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_ACCESS;
            cnt     <= '0;
            isWrite <= reqWrite;
            weOn    <= reqWrite;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (isWrite && cnt == WP_LAST) weOn <= 1'b0;
          if (lastCycle) begin
            state <= ST_IDLE;
            weOn  <= 1'b0;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.latchReq  = accept;
    strb.ceOn      = (state == ST_ACCESS);
    strb.weOn      = weOn;
    strb.captureRd = (state == ST_ACCESS) && !isWrite && (cnt == AA_LAST);
  end

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDout,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDin,
  output logic              memCeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  // request holding registers: change only on acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      memAddr <= '0;
      memDin  <= '0;
    end else if (strb.latchReq) begin
      memAddr <= reqAddr;
      memDin  <= reqWdata;
    end
  end

  // read capture
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.captureRd;
      if (strb.captureRd) rdData <= memDout;
    end
  end

  assign memCeN = ~strb.ceOn;
  assign memWeN = ~strb.weOn;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4,
  parameter int T_WP   = 1,
  parameter int T_WC   = 2,
  parameter int T_AA   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDin,
  input  logic [DATA_W-1:0] memDout
);

  strobeT strb;

  sram_ctrl_fsm #(
    .T_WP(T_WP), .T_WC(T_WC), .T_AA(T_AA)
  ) ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .ready(ready), .strb(strb)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memDout(memDout),
    .memAddr(memAddr), .memDin(memDin), .memCeN(memCeN), .memWeN(memWeN),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              ready,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic [DATA_W-1:0] memDin
);

  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> memCeN);

  // R5
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> !memCeN);

  // R4
  held_request_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && $past(!ready)) |-> ($stable(memAddr) && $stable(memDin)));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  // R9
  rddata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdValid |-> $stable(rdData));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && reqValid) |=> (!ready && !memCeN));

  // R10
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (memCeN && memWeN && ready && !rdValid));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chkInst (.*);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int AW = 16;
  localparam int DW = 4;
  localparam int T_WP = 1;
  localparam int T_WC = 2;
  localparam int T_AA = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic ready, rdValid, memCeN, memWeN;
  logic [DW-1:0] rdData, memDin, memDout;
  logic [AW-1:0] memAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_WP(T_WP), .T_WC(T_WC), .T_AA(T_AA)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .rdValid(rdValid),
    .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN),
    .memDin(memDin), .memDout(memDout)
  );

  // small RAM model, indexed by the low address byte
  logic [DW-1:0] ram [256];
  initial for (int i = 0; i < 256; i++) ram[i] = '0;
  always @(posedge memWeN) if (memCeN === 1'b0) ram[memAddr[7:0]] = memDin;
  assign memDout = (memCeN === 1'b0 && memWeN === 1'b1) ? ram[memAddr[7:0]] : 'z;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 ready", ready, 1); check("R1 ce", memCeN, 1);
    check("R1 we", memWeN, 1); check("R1 rdValid", rdValid, 0);
    check("R1 rdData", rdData, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle ce", memCeN, 1);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] keep = rdData;
    check("R7 ready before", ready, 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;
    for (int n = 1; n <= T_WC + 1; n++) begin
      check("R3 we", memWeN, (n <= T_WP) ? 1'b0 : 1'b1);
      check("R7 ce", memCeN, (n <= T_WC) ? 1'b0 : 1'b1);
      check("R7 ready", ready, (n > T_WC) ? 1'b1 : 1'b0);
      if (n <= T_WC) begin
        check("R4 addr", memAddr, a);
        check("R4 data", memDin, d);
      end
      check("R9 no valid", rdValid, 0);
      check("R9 rdData held", rdData, keep);
      if (n <= T_WC) @(negedge clk);
    end
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    check("R7 ready before", ready, 1);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqWdata = '0;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a;
    for (int n = 1; n <= T_AA + 1; n++) begin
      check("R6 we high", memWeN, 1);
      check("R6 ce", memCeN, (n <= T_AA) ? 1'b0 : 1'b1);
      check("R7 ready", ready, (n > T_AA) ? 1'b1 : 1'b0);
      check("R6 valid", rdValid, (n == T_AA + 1) ? 1'b1 : 1'b0);
      if (n <= T_AA) check("R4 addr", memAddr, a);
      if (n == T_AA + 1) check("R6 data", rdData, exp);
      if (n <= T_AA) @(negedge clk);
    end
    @(negedge clk);
    check("R6 single pulse", rdValid, 0);
  endtask

  task automatic testBusyIgnore();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h0A37; reqWdata = '0;
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = 16'h0B42; reqWdata = 4'h9;
    for (int n = 1; n < T_AA; n++) begin
      check("R8 addr kept", memAddr, 16'h0A37);
      check("R8 no write", memWeN, 1);
      @(negedge clk);
    end
    reqValid = 1'b0;
    check("R8 addr kept", memAddr, 16'h0A37);
    @(negedge clk);
    check("R8 read done", rdValid, 1);
    @(negedge clk);
    check("R8 no extra access", memCeN, 1);
    check("R8 idle", ready, 1);
    doRead(16'h0B42, 4'h0);  // R8 ignored write left no data
  endtask

  task automatic testResetMid();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0C11; reqWdata = 4'h3;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 started", memWeN, 0);
    rst = 1'b1;
    @(negedge clk);
    check("R10 ce", memCeN, 1); check("R10 we", memWeN, 1);
    check("R10 ready", ready, 1); check("R10 valid", rdValid, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    testReset();
    doWrite(16'h0000, 4'h5);
    doWrite(16'hFFFF, 4'hF);
    doWrite(16'h12AB, 4'hA);
    @(negedge clk);
    doRead(16'hFFFF, 4'hF);
    doRead(16'h0000, 4'h5);
    doRead(16'h12AB, 4'hA);
    doWrite(16'h12AB, 4'h0);   // R9 rdData stays 4'hA through this write
    doRead(16'h12AB, 4'h0);
    testBusyIgnore();
    testResetMid();
    check("R2 idle after reset", memCeN, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule